// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit logical address into a physical address by reading two levels of page table from a word-addressed memory. The address splits three ways. The top 12 bits pick a word in the outer table. The next 10 bits pick a word in the inner table that the outer word points to. The low 10 bits are the byte offset inside a 1 KB page. A caller hands over an address with a valid/ready handshake. The walker makes one or two dependent reads through a memory read port that may take any number of cycles. It then returns either the physical address or a fault flag.

Each table word carries a presence flag in bit 31 and a 22-bit frame number in bits 21:0. Bits 30:22 have no meaning to the walker. The outer table begins at the address on the table-root input, which is captured when a request is accepted. An inner table begins at frame number × 1024. Only one translation is in progress at a time. A walk stops at the first absent entry and reports a fault.

Top module: `xlat_walker`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: The first read of a walk is at `tbl_root + req_vaddr[31:20]*4`.
- R3: After a present outer word W, the second read is at `{W[21:0],10'b0} + req_vaddr[19:10]*4`.
- R4: An outer word with bit 31 at 0 ends the walk after that single read, with `rsp_fault` at 1.
- R5: An inner word with bit 31 at 0 ends the walk after exactly two reads, with `rsp_fault` at 1.
- R6: When both words are present, `rsp_paddr` = `{inner[21:0], req_vaddr[9:0]}` and `rsp_fault` = 0. Bits 30:22 of either word have no effect.
- R7: A fault response carries `rsp_paddr` = 0.
- R8: `req_ready` is 0 from the cycle after acceptance until the cycle after the response handshake. A request offered in that span is not taken until then.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds its values.
- R10: `mem_req` is 1 only during a walk. It holds with a stable `mem_addr` until `mem_rvalid` is seen in a cycle where `mem_req` is 1. Data may arrive in the same cycle as the request, or any number of cycles later.
- R11: `tbl_root` is sampled only at acceptance. Changing it during a walk does not alter that walk.
- R12: A response appears in the cycle after the final read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_root | input | 32 | Byte address of the outer table |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Caller takes the response |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Walk hit an absent entry |
| mem_req | output | 1 | Table read requested |
| mem_addr | output | 32 | Table word byte address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Table word |

## Verification
The two functions that can overlap are a stalled response and a fresh request. The bench holds `rsp_ready` low for many cycles while a second request is already offered, and changes `tbl_root` at the same time. A reference model, stepped each clock, then confirms three things. The pending request stays untaken. The held response keeps the first walk's values, computed from the old root. The second walk starts only after the handshake and uses the new root. Memory latencies of zero, one, three and seven cycles move the point where a read returns relative to the state change.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_OUTER = 2'd1,
    WS_INNER = 2'd2,
    WS_RESP  = 2'd3
  } walk_state_e;

endpackage

// File: rtl/xlat_pte_dec.sv
module xlat_pte_dec #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 10
) (
  input  logic [ADDR_W-1:0]       entry,
  output logic                    present,
  output logic [ADDR_W-OFF_W-1:0] frame
);
  localparam int FRAME_W   = ADDR_W - OFF_W;
  localparam int VALID_POS = ADDR_W - 1;

  assign present = entry[VALID_POS];
  assign frame   = entry[FRAME_W-1:0];

  // Bits between the frame field and the presence flag carry no meaning.
  generate
    if (VALID_POS > FRAME_W) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^entry[VALID_POS-1:FRAME_W];
    end
  endgenerate

endmodule

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 10,
  parameter int INNER_W = 10
) (
  input  logic [ADDR_W-1:0]       vaddr,
  input  logic [ADDR_W-1:0]       root,
  input  logic [ADDR_W-OFF_W-1:0] outer_frame,
  input  logic                    sel_inner,
  output logic [ADDR_W-1:0]       rd_addr
);
  localparam int OUTER_W = ADDR_W - OFF_W - INNER_W;

  logic [OUTER_W-1:0] outer_idx;
  logic [INNER_W-1:0] inner_idx;
  logic [ADDR_W-1:0]  outer_ptr;
  logic [ADDR_W-1:0]  inner_ptr;

  assign outer_idx = vaddr[ADDR_W-1 -: OUTER_W];
  assign inner_idx = vaddr[OFF_W +: INNER_W];

  assign outer_ptr = root + {{(ADDR_W-OUTER_W-2){1'b0}}, outer_idx, 2'b00};
  assign inner_ptr = {outer_frame, {OFF_W{1'b0}}}
                   + {{(ADDR_W-INNER_W-2){1'b0}}, inner_idx, 2'b00};

  assign rd_addr = sel_inner ? inner_ptr : outer_ptr;

endmodule

// File: rtl/xlat_fsm.sv
module xlat_fsm
  import xlat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rsp_ready,
  input  logic mem_rvalid,
  input  logic pte_present,
  output logic req_ready,
  output logic mem_req,
  output logic sel_inner,
  output logic rsp_valid,
  output logic take_req,
  output logic take_outer,
  output logic done_ok,
  output logic done_fault
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    req_ready  = 1'b0;
    mem_req    = 1'b0;
    sel_inner  = 1'b0;
    rsp_valid  = 1'b0;
    take_req   = 1'b0;
    take_outer = 1'b0;
    done_ok    = 1'b0;
    done_fault = 1'b0;
    case (state_q)
      WS_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          take_req = 1'b1;
          state_d  = WS_OUTER;
        end
      end
      WS_OUTER: begin
        mem_req = 1'b1;
        if (mem_rvalid) begin
          if (pte_present) begin
            take_outer = 1'b1;
            state_d    = WS_INNER;
          end else begin
            done_fault = 1'b1;
            state_d    = WS_RESP;
          end
        end
      end
      WS_INNER: begin
        mem_req   = 1'b1;
        sel_inner = 1'b1;
        if (mem_rvalid) begin
          state_d = WS_RESP;
          if (pte_present) done_ok    = 1'b1;
          else             done_fault = 1'b1;
        end
      end
      WS_RESP: begin
        rsp_valid = 1'b1;
        if (rsp_ready) state_d = WS_IDLE;
      end
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WS_IDLE;
    else        state_q <= state_d;
  end

  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req) |-> !req_ready);

  // R8
  accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && mem_req));

  // R12
  resp_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid && sel_inner) |=> (rsp_valid && !mem_req));

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 10,
  parameter int INNER_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] tbl_root,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata
);
  localparam int FRAME_W = ADDR_W - OFF_W;

  logic               take_req, take_outer, done_ok, done_fault;
  logic               sel_inner, pte_present;
  logic [FRAME_W-1:0] pte_frame;

  logic [ADDR_W-1:0]  vaddr_q, vaddr_d;
  logic [ADDR_W-1:0]  root_q, root_d;
  logic [FRAME_W-1:0] l1_frame_q, l1_frame_d;
  logic [ADDR_W-1:0]  paddr_q, paddr_d;
  logic               fault_q, fault_d;
  logic               rsp_load;

  xlat_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .rsp_ready   (rsp_ready),
    .mem_rvalid  (mem_rvalid),
    .pte_present (pte_present),
    .req_ready   (req_ready),
    .mem_req     (mem_req),
    .sel_inner   (sel_inner),
    .rsp_valid   (rsp_valid),
    .take_req    (take_req),
    .take_outer  (take_outer),
    .done_ok     (done_ok),
    .done_fault  (done_fault)
  );

  xlat_pte_dec #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
    .entry   (mem_rdata),
    .present (pte_present),
    .frame   (pte_frame)
  );

  xlat_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .INNER_W(INNER_W)) u_agen (
    .vaddr       (vaddr_q),
    .root        (root_q),
    .outer_frame (l1_frame_q),
    .sel_inner   (sel_inner),
    .rd_addr     (mem_addr)
  );

  // Next-state values
  always_comb begin
    vaddr_d    = req_vaddr;
    root_d     = tbl_root;
    l1_frame_d = pte_frame;
    rsp_load   = done_ok || done_fault;
    if (done_ok) begin
      paddr_d = {pte_frame, vaddr_q[OFF_W-1:0]};
      fault_d = 1'b0;
    end else begin
      paddr_d = '0;
      fault_d = 1'b1;
    end
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      root_q  <= '0;
    end else if (take_req) begin
      vaddr_q <= vaddr_d;
      root_q  <= root_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          l1_frame_q <= '0;
    else if (take_outer) l1_frame_q <= l1_frame_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else if (rsp_load) begin
      paddr_q <= paddr_d;
      fault_q <= fault_d;
    end
  end

  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R7
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  // R6
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R4
  outer_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid && !sel_inner && !pte_present) |=> (rsp_valid && rsp_fault && !mem_req));

  // R5
  inner_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid && sel_inner && !pte_present) |=> (rsp_valid && rsp_fault));

  // R3
  second_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid && !sel_inner && pte_present) |=> (mem_req && sel_inner));

endmodule

// File: tb/xlat_walker_bench.sv
`timescale 1ns/1ps
module xlat_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] tbl_root;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  always #2.5 clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk (clk), .rst_n (rst_n), .tbl_root (tbl_root),
    .req_valid (req_valid), .req_ready (req_ready), .req_vaddr (req_vaddr),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault), .mem_req (mem_req), .mem_addr (mem_addr),
    .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [31:0] pmem [logic [31:0]];
  logic [31:0] exp_q [$];
  logic [31:0] got_paddr [$];
  logic        got_fault [$];
  int          phase = 0;
  int          reads_done = 0;
  int          wait_cnt = 0;
  int          lat = 0;
  int          acc_count = 0;
  int          rsp_count = 0;
  logic [31:0] exp_paddr;
  logic        exp_fault;
  int          exp_reads;
  logic        stalled = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (pmem.exists(a)) return pmem[a];
    return 32'h0;
  endfunction

  // Reference walk from the requirements: queue of reads plus final result.
  task automatic model_walk(input logic [31:0] va, input logic [31:0] root);
    logic [31:0] a1, w1, a2, w2;
    a1 = root + ({20'h0, va[31:20]} << 2);
    w1 = rd(a1);
    exp_q.push_back(a1);
    exp_reads = 1;
    if (!w1[31]) begin
      exp_fault = 1'b1; exp_paddr = 32'h0;
    end else begin
      a2 = (w1[21:0] * 32'd1024) + ({22'h0, va[19:10]} << 2);
      w2 = rd(a2);
      exp_q.push_back(a2);
      exp_reads = 2;
      if (!w2[31]) begin
        exp_fault = 1'b1; exp_paddr = 32'h0;
      end else begin
        exp_fault = 1'b0; exp_paddr = {w2[21:0], va[9:0]};
      end
    end
  endtask

  // Cycle-by-cycle comparison and memory model, sampled mid-cycle.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      mem_rvalid = 1'b0;
      if (phase == 0) begin
        chk(req_ready == 1'b1, "R8 ready idle", {31'h0, req_ready}, 32'h1);
        chk(mem_req == 1'b0, "R10 no read idle", {31'h0, mem_req}, 32'h0);
        chk(rsp_valid == 1'b0, "R12 no rsp idle", {31'h0, rsp_valid}, 32'h0);
        if (req_valid) begin
          model_walk(req_vaddr, tbl_root);
          reads_done = 0;
          wait_cnt = 0;
          acc_count++;
          phase = 1;
        end
      end else if (phase == 1) begin
        chk(req_ready == 1'b0, "R8 busy", {31'h0, req_ready}, 32'h0);
        chk(mem_req == 1'b1, "R10 read held", {31'h0, mem_req}, 32'h1);
        chk(rsp_valid == 1'b0, "R12 early rsp", {31'h0, rsp_valid}, 32'h0);
        if (exp_q.size() > 0) begin
          chk(mem_addr == exp_q[0], (reads_done == 0) ? "R2 outer addr" : "R3 inner addr",
              mem_addr, exp_q[0]);
          if (wait_cnt >= lat) begin
            mem_rvalid = 1'b1;
            mem_rdata  = rd(mem_addr);
            void'(exp_q.pop_front());
            reads_done++;
            wait_cnt = 0;
            if (exp_q.size() == 0) phase = 2;
          end else begin
            wait_cnt++;
          end
        end
      end else begin
        chk(rsp_valid == 1'b1, "R12 rsp due", {31'h0, rsp_valid}, 32'h1);
        chk(mem_req == 1'b0, exp_reads == 1 ? "R4 extra read" : "R5 extra read",
            {31'h0, mem_req}, 32'h0);
        chk(req_ready == 1'b0, "R8 ready during rsp", {31'h0, req_ready}, 32'h0);
        chk(rsp_fault == exp_fault, stalled ? "R9 fault held" :
            (exp_reads == 1 ? "R4 fault" : "R5/R6 fault"), {31'h0, rsp_fault}, {31'h0, exp_fault});
        chk(rsp_paddr == exp_paddr, stalled ? "R9 paddr held" :
            (exp_fault ? "R7 paddr" : "R6 paddr"), rsp_paddr, exp_paddr);
        stalled = !rsp_ready;
        if (rsp_ready) begin
          got_paddr.push_back(rsp_paddr);
          got_fault.push_back(rsp_fault);
          rsp_count++;
          phase = 0;
        end
      end
    end
  end

  task automatic finish_tb;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      finish_tb();
    end
  end

  task automatic map_page(input logic [31:0] root, input logic [31:0] va,
                          input logic [21:0] l1frame, input logic [31:0] inner_word,
                          input logic [8:0] rsvd);
    pmem[root + ({20'h0, va[31:20]} << 2)] = {1'b1, rsvd, l1frame};
    pmem[(l1frame * 32'd1024) + ({22'h0, va[19:10]} << 2)] = inner_word;
  endtask

  task automatic send(input logic [31:0] va);
    int target;
    target = acc_count + 1;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    do @(negedge clk); while (acc_count < target);
    req_valid = 1'b0;
  endtask

  task automatic translate(input logic [31:0] va, input int l);
    int target;
    lat = l;
    target = rsp_count + 1;
    send(va);
    while (rsp_count < target) @(negedge clk);
  endtask

  localparam logic [31:0] ROOT0 = 32'h0004_0000;
  localparam logic [31:0] ROOT1 = 32'h0008_0000;

  initial begin
    rst_n = 1'b0; tbl_root = ROOT0; req_valid = 1'b0; req_vaddr = '0;
    rsp_ready = 1'b1; mem_rvalid = 1'b0; mem_rdata = '0;

    map_page(ROOT0, 32'h1234_5678, 22'h00200, {1'b1, 9'h0, 22'h0ABCD}, 9'h0);
    map_page(ROOT0, 32'hFFFF_FFFF, 22'h00201, {1'b1, 9'h1FF, 22'h3FFFFF}, 9'h155);
    map_page(ROOT0, 32'h0000_0000, 22'h00202, {1'b1, 9'h0, 22'h000001}, 9'h0);
    pmem[ROOT0 + (32'h777 << 2)] = 32'h7FFF_FFFF;
    map_page(ROOT0, 32'h3210_0400, 22'h00203, 32'h003F_0000, 9'h0);
    map_page(ROOT1, 32'h2340_0C00, 22'h00300, {1'b1, 9'h0, 22'h012345}, 9'h0);

    repeat (3) @(negedge clk);
    // R1: reset values
    chk(req_ready == 1'b1, "R1 ready", {31'h0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk(mem_req == 1'b0, "R1 mem_req", {31'h0, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 present at both levels, data in the same cycle as the request
    translate(32'h1234_5678, 0);
    chk(got_paddr[$] == 32'h02AF_3678, "R6 latency0", got_paddr[$], 32'h02AF_3678);
    // R6 maximal indices, reserved bits set, latency 3
    translate(32'hFFFF_FFFF, 3);
    chk(got_paddr[$] == 32'hFFFF_FFFF && got_fault[$] == 1'b0, "R6 max", got_paddr[$], 32'hFFFF_FFFF);
    // R2 zero indices, latency 1
    translate(32'h0000_0000, 1);
    chk(got_paddr[$] == 32'h0000_0400, "R2 zero index", got_paddr[$], 32'h0000_0400);
    // R4 outer absent (empty word, then flag clear with other bits set)
    translate(32'h5550_0123, 2);
    chk(got_fault[$] == 1'b1 && got_paddr[$] == 32'h0, "R4/R7 empty outer", got_paddr[$], 32'h0);
    translate(32'h7770_0000, 0);
    chk(got_fault[$] == 1'b1, "R4 flag clear outer", {31'h0, got_fault[$]}, 32'h1);
    // R5 inner absent, long latency
    translate(32'h3210_0400, 7);
    chk(got_fault[$] == 1'b1 && got_paddr[$] == 32'h0, "R5 inner absent", got_paddr[$], 32'h0);

    // R8/R9/R11: stalled response, waiting request, root changed mid-walk
    lat = 1;
    rsp_ready = 1'b0;
    send(32'h1234_5678);
    tbl_root  = ROOT1;
    req_valid = 1'b1;
    req_vaddr = 32'h2340_0C00;
    repeat (14) @(negedge clk);
    chk(acc_count == 7, "R8 no second accept", acc_count, 7);
    rsp_ready = 1'b1;
    while (acc_count < 8) @(negedge clk);
    req_valid = 1'b0;
    while (rsp_count < 8) @(negedge clk);
    chk(got_paddr[6] == 32'h02AF_3678, "R11 old root kept", got_paddr[6], 32'h02AF_3678);
    chk(got_paddr[7] == {22'h012345, 10'h000}, "R11 new root used", got_paddr[7], {22'h012345, 10'h000});

    repeat (3) @(negedge clk);
    finish_tb();
  end

endmodule